// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address used on each cycle of a synchronous burst memory access. A burst opens when either of two start strobes is sampled high while the chip select is high. The full external address is then captured. From that point the block produces the following addresses itself. On every cycle where the advance input is high, only the low burst-index bits move. The upper address bits stay where the start strobe put them.

A static order input chooses how the burst index walks:

- **Sequential order:** the low bits count up modulo four from the starting value.
- **Interleaved order:** the low bits are the starting value XOR a running count of 0, 1, 2, 3.

In both orders the fifth address equals the first, so a burst that keeps advancing wraps back to where it began. Bursting is optional. A controller may present a new external address with a start strobe on every cycle, and each one is taken without a gap.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, `cur_addr` is all zeros.
- R2: `start_host` sampled high with `sel` high at a rising edge makes `cur_addr` equal the `ext_addr` of that edge, starting right after that edge.
- R3: `start_ctrl` sampled high with `sel` high has the same load effect as `start_host`. Both strobes high together also load `ext_addr`.
- R4: A start strobe sampled while `sel` is low has no effect. The address behaves as if the strobe were absent: it holds, or it advances if `adv` is high.
- R5: With `order_il` = 0 (sequential), each edge with `adv` high and no effective strobe adds one modulo 4 to `cur_addr[1:0]` and leaves `cur_addr[ADDR_W-1:2]` unchanged.
- R6: With `order_il` = 1 (interleaved), the n-th advance after a load gives `cur_addr[1:0]` = start[1:0] XOR (n mod 4), with the upper bits unchanged.
- R7: An edge with `adv` low and no effective strobe leaves `cur_addr` unchanged.
- R8: After four advances, in either order, `cur_addr` equals the loaded start address again.
- R9: An effective start strobe together with `adv` high loads `ext_addr`; the advance is discarded.
- R10: Effective start strobes on consecutive cycles load each new `ext_addr` on every edge with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; all inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select; start strobes count only while it is high |
| start_host | input | 1 | First burst-start strobe |
| start_ctrl | input | 1 | Second burst-start strobe |
| adv | input | 1 | Advance the burst index by one step |
| order_il | input | 1 | Burst order: 0 sequential, 1 interleaved |
| ext_addr | input | ADDR_W | External address captured by a start strobe |
| cur_addr | output | ADDR_W | Address for the current cycle |

## Verification
Two functions can fall in the same cycle:

- a load, from either strobe or from both strobes together;
- an advance.

The bench raises `adv` on the same edges as gated and ungated strobes. It also holds strobes on for several cycles in a row while `adv` toggles.

A behavioural model, built on integer sums and XORs, predicts each address, and the output is compared with it on every clock. When a load and an advance coincide, the result counts as correct only if the new external address appears with a fresh index. When a strobe is gated off by `sel`, the expected result is the advance.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_IL  = 1'b1
  } burst_order_e;

  // sequential order: start plus step count, wrapping in BURST_W bits
  function automatic logic [BURST_W-1:0] idx_seq(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step
  );
    return start + step;
  endfunction

  // interleaved order: start with step count folded in by XOR
  function automatic logic [BURST_W-1:0] idx_il(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step
  );
    return start ^ step;
  endfunction

  function automatic logic [BURST_W-1:0] step_next(
    input logic [BURST_W-1:0] step
  );
    return step + 1'b1;
  endfunction

endpackage

// File: rtl/bas_counter.sv
module bas_counter
  import bas_pkg::*;
#(
  parameter int unsigned CNT_W = BURST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_en,
  output logic [CNT_W-1:0] step
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (clear) begin
      step <= '0;
    end else if (step_en) begin
      step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/bas_latch.sv
module bas_latch #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bas_order.sv
module bas_order
  import bas_pkg::*;
#(
  parameter int unsigned IDX_W = BURST_W
) (
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] step,
  input  logic             order_il,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_s;
  logic [IDX_W-1:0] idx_x;

  always_comb begin
    idx_s = start_idx + step;
    idx_x = start_idx ^ step;
    idx   = (order_il == ORD_IL) ? idx_x : idx_s;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              start_host,
  input  logic              start_ctrl,
  input  logic              adv,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int unsigned IDX_W = BURST_W;
  localparam int unsigned HI_W  = ADDR_W - IDX_W;

  // named events for the checker
  logic load_evt;
  logic step_evt;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  step_q;
  logic [IDX_W-1:0]  idx;

  assign load_evt = sel & (start_host | start_ctrl);
  assign step_evt = adv & ~load_evt;

  bas_latch #(.WIDTH(ADDR_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .d     (ext_addr),
    .q     (base_q)
  );

  bas_counter #(.CNT_W(IDX_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load_evt),
    .step_en (step_evt),
    .step    (step_q)
  );

  bas_order #(.IDX_W(IDX_W)) u_order (
    .start_idx (base_q[IDX_W-1:0]),
    .step      (step_q),
    .order_il  (order_il),
    .idx       (idx)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign cur_addr = {base_q[ADDR_W-1:IDX_W], idx};
    end else begin : g_nohi
      assign cur_addr = idx;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              start_host,
  input logic              start_ctrl,
  input logic              adv,
  input logic              order_il,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              load_evt,
  input logic              step_evt
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (cur_addr == '0);
    end
  end

  // R2 / R3 / R9 / R10: any effective strobe loads the external address
  property p_load;
    @(posedge clk) disable iff (!rst_n)
      (sel && (start_host || start_ctrl)) |=> (cur_addr == $past(ext_addr));
  endproperty
  assert_load_R2: assert property (p_load);

  property p_gated;
    @(posedge clk) disable iff (!rst_n)
      (!sel && !adv) |=> $stable(cur_addr);
  endproperty
  assert_gated_strobe_R4: assert property (p_gated);

  property p_hold;
    @(posedge clk) disable iff (!rst_n)
      (!adv && !load_evt) |=> $stable(cur_addr);
  endproperty
  assert_hold_R7: assert property (p_hold);

  property p_upper;
    @(posedge clk) disable iff (!rst_n)
      step_evt |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));
  endproperty
  assert_upper_fixed_R5: assert property (p_upper);

  property p_seq_step;
    @(posedge clk) disable iff (!rst_n)
      (step_evt && !order_il) |=>
        (order_il || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);
  endproperty
  assert_seq_step_R5: assert property (p_seq_step);

  property p_il_change;
    @(posedge clk) disable iff (!rst_n)
      (step_evt && order_il) |=>
        (!order_il || cur_addr[1:0] != $past(cur_addr[1:0]));
  endproperty
  assert_il_moves_R6: assert property (p_il_change);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .start_host (start_host),
  .start_ctrl (start_ctrl),
  .adv        (adv),
  .order_il   (order_il),
  .ext_addr   (ext_addr),
  .cur_addr   (cur_addr),
  .load_evt   (load_evt),
  .step_evt   (step_evt)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel = 1'b0;
  logic              start_host = 1'b0;
  logic              start_ctrl = 1'b0;
  logic              adv = 1'b0;
  logic              order_il = 1'b0;
  logic [ADDR_W-1:0] ext_addr = '0;
  logic [ADDR_W-1:0] cur_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_base = 0;
  int m_n = 0;
  string pend_req = "R1";

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .start_host(start_host),
    .start_ctrl(start_ctrl), .adv(adv), .order_il(order_il),
    .ext_addr(ext_addr), .cur_addr(cur_addr)
  );

  function automatic int model_addr(int base, int n, bit il);
    int lo;
    int s;
    s = base % 4;
    if (il) lo = s ^ n;
    else lo = (s + n) % 4;
    return (base - s) + lo;
  endfunction

  task automatic compare();
    int exp;
    exp = model_addr(m_base, m_n, order_il);
    checks++;
    if (cur_addr !== ADDR_W'(exp)) begin
      fails++;
      $display("FAIL %s: cur_addr=%h expected=%h", pend_req, cur_addr, ADDR_W'(exp));
    end
  endtask

  // present inputs at a falling edge, advance the model to the next rising edge
  task automatic step(input bit s, input bit sh, input bit sc, input bit a,
                      input bit il, input int ea, input string req);
    @(negedge clk);
    compare();
    sel = s; start_host = sh; start_ctrl = sc; adv = a; order_il = il;
    ext_addr = ADDR_W'(ea);
    pend_req = req;
    if (s && (sh || sc)) begin
      m_base = ea;
      m_n = 0;
    end else if (a) begin
      m_n = (m_n + 1) % 4;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with strobes and advance active
    rst_n = 1'b0;
    sel = 1; start_host = 1; adv = 1; ext_addr = 18'h2abcd;
    repeat (3) begin
      @(negedge clk);
      pend_req = "R1";
      compare();
    end
    sel = 0; start_host = 0; adv = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");

    // R2 load then R5 sequential advances, R8 wrap
    step(1, 1, 0, 0, 0, 32'h12346, "R2");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 32'h3ffff, "R5_R8");
    // R7 hold with adv low
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 32'h00001, "R7");

    // R3 second strobe, R6 interleaved, R8 wrap
    step(1, 0, 1, 0, 1, 32'h0a5a7, "R3");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 1, 32'h11111, "R6_R8");
    step(1, 1, 1, 0, 1, 32'h20001, "R3");
    for (int i = 0; i < 4; i++) step(1, 0, 0, i % 2 == 0, 1, 0, "R6_R7");

    // R4 gated strobes: hold, then advance despite strobe
    step(0, 1, 0, 0, 0, 32'h1ffff, "R4");
    step(0, 0, 1, 0, 0, 32'h1fffe, "R4");
    step(0, 1, 1, 1, 0, 32'h00000, "R4");
    step(0, 1, 0, 1, 1, 32'h15555, "R4");

    // R9 strobe and advance together
    step(1, 0, 0, 1, 0, 0, "R5");
    step(1, 1, 0, 1, 0, 32'h0beef, "R9");
    step(1, 0, 1, 1, 1, 32'h30002, "R9");
    step(1, 0, 0, 1, 1, 0, "R6");

    // R10 back-to-back loads
    for (int i = 0; i < 8; i++)
      step(1, i % 2 == 0, i % 3 != 0, i % 2 == 1, i % 2, 32'h01000 + i * 37, "R10");
    step(1, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, 0, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule